// File: doc/BRIEF.md
# Banking-Aware Accelerator Address Decoder

This block sits between the fast CPU on an accelerator cartridge and the memories around it. For every CPU access it takes the address, the read/write flag and three emulated banking bits (a low-ROM enable, a high-ROM enable and a character/I/O select). From these it works out which single target serves the access: the local system ROM, one of two 32K local SRAM banks, or the host I/O window. ROM reads are given a redirected ROM address, so that three banked images share one 32K ROM.

The host's own mapping logic never sees the emulated banking bits, so on the host side the page 0xD000–0xDFFF is always I/O. The decoder therefore asks for a host bus cycle in only two cases: an I/O access, or a CPU write to RAM outside that page, which is copied to host RAM so the video chip sees screen updates. When a host cycle is needed, a three-state sequencer (IDLE, HOST, RELEASE) holds the CPU off until the host reports that the cycle has finished.

Sequencer transitions: IDLE→HOST when a valid access needs the host; HOST→HOST while `host_ack` is low; HOST→RELEASE on `host_ack`; RELEASE→IDLE always. Reset enters IDLE.

Top module: `accel_mem_decoder`

## Requirements
- R1: Local RAM bank select is address bit 15. `ram_ce[0]` serves 0x0000–0x7FFF and `ram_ce[1]` serves 0x8000–0xFFFF.
- R2: A read in 0xA000–0xBFFF with low-ROM and high-ROM both 1 asserts `rom_ce` with `rom_addr` = 0x0000 + address bits 12:0. With any other bank setting the read goes to local RAM.
- R3: A read in 0xE000–0xFFFF with high-ROM 1 asserts `rom_ce` with `rom_addr` = 0x2000 + address bits 12:0. With high-ROM 0 the read goes to local RAM.
- R4: In 0xD000–0xDFFF the access goes to local RAM when low-ROM and high-ROM are both 0. Otherwise it is I/O when the char/I/O bit is 1. When that bit is 0, a read gives `rom_ce` with `rom_addr` = 0x4000 + address bits 11:0.
- R5: A write never asserts `rom_ce`. A write to a ROM-mapped region (including the character image) enables the underlying local RAM bank instead.
- R6: A write that targets local RAM outside 0xD000–0xDFFF requests a host cycle (write-through). A read from local RAM never does.
- R7: A non-I/O access in 0xD000–0xDFFF never requests a host cycle and never stalls the CPU.
- R8: An I/O access (read or write) asserts `io_sel`, enables no local memory and requests a host cycle.
- R9: When a host cycle is needed, `cpu_ready` is low in the access cycle. `host_req` is high from the next cycle and stays high until `host_ack` is sampled. In the cycle after that, `cpu_ready` is high and `host_req` is low, and the sequencer then returns to IDLE.
- R10: With `cpu_valid` low in IDLE, all enables are 0, `rom_addr` is 0, `cpu_ready` is 1 and `host_req` is 0.
- R11: After reset, `host_req` is 0 and the sequencer is in IDLE.
- R12: At most one of `rom_ce`, `io_sel` and the `ram_ce` bits is high in any cycle. `rom_addr` is 0 whenever `rom_ce` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | CPU access strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| bank_loram | input | 1 | Emulated low-ROM enable bit |
| bank_hiram | input | 1 | Emulated high-ROM enable bit |
| bank_charen | input | 1 | Emulated char-ROM/I/O select bit (1 = I/O) |
| host_ack | input | 1 | Host bus cycle finished |
| rom_ce | output | 1 | Local ROM enable |
| ram_ce | output | 2 | Local SRAM bank enables |
| io_sel | output | 1 | I/O access detected |
| rom_addr | output | 15 | Redirected local ROM address |
| host_req | output | 1 | Host bus cycle request |
| cpu_ready | output | 1 | CPU may complete the access |

## Verification
The bench targets the edges of each window: 0x7FFF/0x8000 for the bank split, 0x9FFF/0xA000 and 0xBFFF/0xC000 around the low ROM, and 0xD000/0xDFFF under all three outcomes of the D page. A wrong bank bit would enable the wrong SRAM, and an off-by-one window would read ROM from RAM space. A decoder that wrote through on D-page RAM writes would corrupt host I/O, and one that sent writes to ROM would lose data; both show up in the enables and in the stall. The handshake is checked with `host_ack` held low for an extra cycle, so a sequencer that released early or re-requested would be caught.

// File: rtl/accel_dec_pkg.sv
package accel_dec_pkg;

    // Target class of one CPU access after banking is applied
    typedef enum logic [2:0] {
        RGN_RAM    = 3'd0,
        RGN_BASIC  = 3'd1,
        RGN_KERNAL = 3'd2,
        RGN_CHAR   = 3'd3,
        RGN_IO     = 3'd4
    } region_e;

    // Host bus handshake sequencer
    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_HOST    = 2'd1,
        SEQ_RELEASE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic loram;
        logic hiram;
        logic charen;
    } bank_bits_t;

endpackage

// File: rtl/accel_region_decode.sv
module accel_region_decode
    import accel_dec_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  bank_bits_t        bank,
    output region_e           region
);
    localparam int PAGE_LSB = ADDR_W - 4;

    logic [3:0] page;
    assign page = addr[ADDR_W-1:PAGE_LSB];

    always_comb begin
        region = RGN_RAM;
        case (page)
            4'hA, 4'hB: begin
                if (bank.loram && bank.hiram)
                    region = RGN_BASIC;
            end
            4'hD: begin
                if (bank.loram || bank.hiram)
                    region = bank.charen ? RGN_IO : RGN_CHAR;
            end
            4'hE, 4'hF: begin
                if (bank.hiram)
                    region = RGN_KERNAL;
            end
            default: region = RGN_RAM;
        endcase
    end
endmodule

// File: rtl/accel_rom_redirect.sv
module accel_rom_redirect
    import accel_dec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ROM_AW = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  region_e           region,
    output logic [ROM_AW-1:0] rom_addr
);
    // 8K images for the two main ROMs, 4K for the character image
    localparam int MAIN_OFS_W = ADDR_W - 3;
    localparam int CHAR_OFS_W = ADDR_W - 4;
    localparam logic [ROM_AW-1:0] KERNAL_BASE = ROM_AW'(1) << MAIN_OFS_W;
    localparam logic [ROM_AW-1:0] CHAR_BASE   = ROM_AW'(1) << (MAIN_OFS_W + 1);

    logic [ROM_AW-1:0] main_ofs;
    logic [ROM_AW-1:0] char_ofs;

    assign main_ofs = ROM_AW'(addr[MAIN_OFS_W-1:0]);
    assign char_ofs = ROM_AW'(addr[CHAR_OFS_W-1:0]);

    always_comb begin
        unique case (region)
            RGN_BASIC:  rom_addr = main_ofs;
            RGN_KERNAL: rom_addr = KERNAL_BASE | main_ofs;
            RGN_CHAR:   rom_addr = CHAR_BASE | char_ofs;
            default:    rom_addr = '0;
        endcase
    end
endmodule

// File: rtl/accel_bank_enable.sv
module accel_bank_enable #(
    parameter int ADDR_W    = 16,
    parameter int NUM_BANKS = 2
) (
    input  logic                 active,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] ram_ce
);
    localparam int SEL_W = $clog2(NUM_BANKS);

    logic [SEL_W-1:0] sel;
    assign sel = addr[ADDR_W-1 -: SEL_W];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign ram_ce[g] = active && (sel == SEL_W'(g));
    end
endmodule

// File: rtl/accel_host_seq.sv
module accel_host_seq
    import accel_dec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic host_ack,
    output logic host_req,
    output logic cpu_ready
);
    seq_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SEQ_IDLE;
        else
            state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            SEQ_IDLE:    state_nxt = start ? SEQ_HOST : SEQ_IDLE;
            SEQ_HOST:    state_nxt = host_ack ? SEQ_RELEASE : SEQ_HOST;
            SEQ_RELEASE: state_nxt = SEQ_IDLE;
            default:     state_nxt = SEQ_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            SEQ_IDLE: begin
                host_req  = 1'b0;
                cpu_ready = !start;
            end
            SEQ_HOST: begin
                host_req  = 1'b1;
                cpu_ready = 1'b0;
            end
            SEQ_RELEASE: begin
                host_req  = 1'b0;
                cpu_ready = 1'b1;
            end
            default: begin
                host_req  = 1'b0;
                cpu_ready = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/accel_mem_decoder.sv
module accel_mem_decoder
    import accel_dec_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int ROM_AW    = 15,
    parameter int NUM_BANKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_valid,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic                 cpu_rw,
    input  logic                 bank_loram,
    input  logic                 bank_hiram,
    input  logic                 bank_charen,
    input  logic                 host_ack,
    output logic                 rom_ce,
    output logic [NUM_BANKS-1:0] ram_ce,
    output logic                 io_sel,
    output logic [ROM_AW-1:0]    rom_addr,
    output logic                 host_req,
    output logic                 cpu_ready
);
    localparam int PAGE_LSB = ADDR_W - 4;

    bank_bits_t        bank;
    region_e           region;
    logic [ROM_AW-1:0] rom_addr_raw;
    logic              rom_region;
    logic              ram_access;
    logic              d_page;
    logic              need_host;

    assign bank = '{loram: bank_loram, hiram: bank_hiram, charen: bank_charen};

    accel_region_decode #(.ADDR_W(ADDR_W)) u_region (
        .addr   (cpu_addr),
        .bank   (bank),
        .region (region)
    );

    accel_rom_redirect #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW)) u_redirect (
        .addr     (cpu_addr),
        .region   (region),
        .rom_addr (rom_addr_raw)
    );

    assign rom_region = (region == RGN_BASIC) || (region == RGN_KERNAL)
                     || (region == RGN_CHAR);
    assign d_page     = (cpu_addr[ADDR_W-1:PAGE_LSB] == 4'hD);

    // Writes under a ROM image land in the RAM below it
    assign ram_access = cpu_valid && ((region == RGN_RAM) || (!cpu_rw && rom_region));
    assign rom_ce     = cpu_valid && cpu_rw && rom_region;
    assign io_sel     = cpu_valid && (region == RGN_IO);
    assign rom_addr   = rom_ce ? rom_addr_raw : '0;

    // Host page D is always I/O, so RAM there is never written through
    assign need_host  = io_sel || (ram_access && !cpu_rw && !d_page);

    accel_bank_enable #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_banks (
        .active (ram_access),
        .addr   (cpu_addr),
        .ram_ce (ram_ce)
    );

    accel_host_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cpu_valid && need_host),
        .host_ack  (host_ack),
        .host_req  (host_req),
        .cpu_ready (cpu_ready)
    );
endmodule

// File: rtl/accel_dec_checker.sv
module accel_dec_checker #(
    parameter int ADDR_W    = 16,
    parameter int ROM_AW    = 15,
    parameter int NUM_BANKS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cpu_valid,
    input logic [ADDR_W-1:0]    cpu_addr,
    input logic                 cpu_rw,
    input logic                 host_ack,
    input logic                 rom_ce,
    input logic [NUM_BANKS-1:0] ram_ce,
    input logic                 io_sel,
    input logic [ROM_AW-1:0]    rom_addr,
    input logic                 host_req,
    input logic                 cpu_ready
);
    logic d_page;
    assign d_page = (cpu_addr[ADDR_W-1 -: 4] == 4'hD);

    assert_rom_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rom_ce |-> cpu_rw);

    assert_single_target_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_ce, io_sel, ram_ce}));

    assert_rom_addr_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_ce |-> (rom_addr == '0));

    assert_io_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> d_page);

    assert_dpage_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && d_page && !io_sel && !host_req) |-> cpu_ready);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_ack) |=> host_req);

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ack) |=> (cpu_ready && !host_req));

    assert_idle_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_valid && !host_req) |-> cpu_ready);
endmodule

bind accel_mem_decoder accel_dec_checker #(
    .ADDR_W(ADDR_W), .ROM_AW(ROM_AW), .NUM_BANKS(NUM_BANKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_valid (cpu_valid),
    .cpu_addr  (cpu_addr),
    .cpu_rw    (cpu_rw),
    .host_ack  (host_ack),
    .rom_ce    (rom_ce),
    .ram_ce    (ram_ce),
    .io_sel    (io_sel),
    .rom_addr  (rom_addr),
    .host_req  (host_req),
    .cpu_ready (cpu_ready)
);

// File: tb/accel_mem_decoder_test.sv
`timescale 1ns/1ps
module accel_mem_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rw = 1'b1;
    logic        bank_loram = 1'b1;
    logic        bank_hiram = 1'b1;
    logic        bank_charen = 1'b1;
    logic        host_ack = 1'b0;
    logic        rom_ce;
    logic [1:0]  ram_ce;
    logic        io_sel;
    logic [14:0] rom_addr;
    logic        host_req;
    logic        cpu_ready;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    accel_mem_decoder uut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
        .cpu_rw(cpu_rw), .bank_loram(bank_loram), .bank_hiram(bank_hiram),
        .bank_charen(bank_charen), .host_ack(host_ack), .rom_ce(rom_ce),
        .ram_ce(ram_ce), .io_sel(io_sel), .rom_addr(rom_addr),
        .host_req(host_req), .cpu_ready(cpu_ready)
    );

    // {addr[39:24], rw[23], loram hiram charen[22:20], rom[19], ram[18:17], io[16], host[15], rom_addr[14:0]}
    localparam int NV = 20;
    localparam logic [39:0] VEC [NV] = '{
        {16'hA123, 1'b1, 3'b111, 1'b1, 2'b00, 1'b0, 1'b0, 15'h0123}, // R2 low ROM
        {16'hA123, 1'b1, 3'b011, 1'b0, 2'b10, 1'b0, 1'b0, 15'h0000}, // R2 low ROM off
        {16'hE456, 1'b1, 3'b011, 1'b1, 2'b00, 1'b0, 1'b0, 15'h2456}, // R3 high ROM
        {16'hE456, 1'b1, 3'b101, 1'b0, 2'b10, 1'b0, 1'b0, 15'h0000}, // R3 high ROM off
        {16'hD020, 1'b1, 3'b111, 1'b0, 2'b00, 1'b1, 1'b1, 15'h0000}, // R8 I/O read
        {16'hD020, 1'b0, 3'b111, 1'b0, 2'b00, 1'b1, 1'b1, 15'h0000}, // R8 I/O write
        {16'hD123, 1'b1, 3'b110, 1'b1, 2'b00, 1'b0, 1'b0, 15'h4123}, // R4 char image
        {16'hD123, 1'b1, 3'b001, 1'b0, 2'b10, 1'b0, 1'b0, 15'h0000}, // R4 D-page RAM
        {16'hD123, 1'b0, 3'b110, 1'b0, 2'b10, 1'b0, 1'b0, 15'h0000}, // R5 R7 write under char
        {16'h0400, 1'b0, 3'b111, 1'b0, 2'b01, 1'b0, 1'b1, 15'h0000}, // R6 write-through
        {16'h0400, 1'b1, 3'b111, 1'b0, 2'b01, 1'b0, 1'b0, 15'h0000}, // R6 local read
        {16'hA000, 1'b0, 3'b111, 1'b0, 2'b10, 1'b0, 1'b1, 15'h0000}, // R5 write under ROM
        {16'hFFFF, 1'b0, 3'b011, 1'b0, 2'b10, 1'b0, 1'b1, 15'h0000}, // R5 write under ROM
        {16'h7FFF, 1'b1, 3'b111, 1'b0, 2'b01, 1'b0, 1'b0, 15'h0000}, // R1 bank edge
        {16'h8000, 1'b1, 3'b111, 1'b0, 2'b10, 1'b0, 1'b0, 15'h0000}, // R1 bank edge
        {16'hBFFF, 1'b1, 3'b111, 1'b1, 2'b00, 1'b0, 1'b0, 15'h1FFF}, // R2 top edge
        {16'hC000, 1'b1, 3'b111, 1'b0, 2'b10, 1'b0, 1'b0, 15'h0000}, // R2 past top
        {16'hDFFF, 1'b1, 3'b010, 1'b1, 2'b00, 1'b0, 1'b0, 15'h4FFF}, // R4 char edge
        {16'hD000, 1'b0, 3'b011, 1'b0, 2'b00, 1'b1, 1'b1, 15'h0000}, // R4 R8 I/O edge
        {16'h9FFF, 1'b1, 3'b111, 1'b0, 2'b10, 1'b0, 1'b0, 15'h0000}  // R2 below window
    };

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string tag);
        chk(cpu_ready == 1'b1, {tag, " cpu_ready idle"}, int'(cpu_ready), 1);
        chk(host_req == 1'b0, {tag, " host_req idle"}, int'(host_req), 0);
        chk({rom_ce, ram_ce, io_sel} == 4'b0, {tag, " enables idle"},
            int'({rom_ce, ram_ce, io_sel}), 0);
        chk(rom_addr == 15'h0, {tag, " rom_addr idle"}, int'(rom_addr), 0);
    endtask

    task automatic run_vec(input logic [39:0] v);
        logic exp_host;
        exp_host = v[15];
        @(negedge clk);
        cpu_addr    = v[39:24];
        cpu_rw      = v[23];
        bank_loram  = v[22];
        bank_hiram  = v[21];
        bank_charen = v[20];
        cpu_valid   = 1'b1;
        #2;
        chk(rom_ce == v[19], "R2 R3 R4 R5 rom_ce", int'(rom_ce), int'(v[19]));
        chk(ram_ce == v[18:17], "R1 R5 ram_ce", int'(ram_ce), int'(v[18:17]));
        chk(io_sel == v[16], "R8 io_sel", int'(io_sel), int'(v[16]));
        chk(rom_addr == v[14:0], "R2 R3 R4 R12 rom_addr", int'(rom_addr), int'(v[14:0]));
        chk(cpu_ready == !exp_host, "R6 R7 R8 cpu_ready", int'(cpu_ready), int'(!exp_host));
        chk(host_req == 1'b0, "R9 host_req first cycle", int'(host_req), 0);
        if (exp_host) begin
            @(negedge clk); #2;
            chk(host_req == 1'b1, "R9 host_req raised", int'(host_req), 1);
            chk(cpu_ready == 1'b0, "R9 stall", int'(cpu_ready), 0);
            @(negedge clk); #2;
            chk(host_req == 1'b1, "R9 host_req held", int'(host_req), 1);
            host_ack = 1'b1;
            @(negedge clk);
            host_ack = 1'b0;
            #2;
            chk(host_req == 1'b0, "R9 host_req dropped", int'(host_req), 0);
            chk(cpu_ready == 1'b1, "R9 release ready", int'(cpu_ready), 1);
        end
        @(negedge clk);
        cpu_valid = 1'b0;
        #2;
        check_idle("R10");
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk(host_req == 1'b0, "R11 host_req in reset", int'(host_req), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check_idle("R11");

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R10: bank changes with no access enable nothing
        @(negedge clk);
        bank_loram = 1'b1; bank_hiram = 1'b1; bank_charen = 1'b1;
        cpu_addr = 16'hD020;
        #2;
        check_idle("R10 no access");

        // R9: long host wait, then back-to-back write-through
        @(negedge clk);
        cpu_addr = 16'h2000; cpu_rw = 1'b0; cpu_valid = 1'b1;
        repeat (5) begin
            @(negedge clk); #2;
            chk(host_req == 1'b1 && cpu_ready == 1'b0, "R9 long wait",
                int'({host_req, cpu_ready}), 2);
        end
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        cpu_addr = 16'h2001;
        #2;
        chk(cpu_ready == 1'b1 && host_req == 1'b0, "R9 release after wait",
            int'({host_req, cpu_ready}), 1);
        @(negedge clk); #2;
        chk(cpu_ready == 1'b0 && host_req == 1'b0, "R6 R9 second write stalls",
            int'({host_req, cpu_ready}), 0);
        @(negedge clk); #2;
        chk(host_req == 1'b1, "R9 second request", int'(host_req), 1);
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        @(negedge clk);
        cpu_valid = 1'b0;
        #2;
        check_idle("R10 end");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule